// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave that acts as a small serial EEPROM on an open-drain two-wire bus. A fast system clock samples the clock line (SCL) and the data line (SDA). The block finds START and STOP conditions, shifts bytes in and out, and pulls SDA low for acknowledge and for zero data bits. Its storage is a 512-byte array. The array powers up, and resets, with every byte set to 0xFF.

A master can write a single byte or up to a page of sixteen bytes. Written bytes first collect in a page buffer. They reach the array only during a self-timed write window that opens at STOP, and the window's length is a parameter counted in system clock cycles. While the window is open the slave refuses its own address, so the master can poll for completion. Reads come in three forms: from the current address, from a chosen address (a dummy write followed by a repeated START), or sequential. A write-protect input locks the upper 256 bytes.

Top module: `tw_eeprom`

## Requirements
- R1: After reset the slave releases SDA (`sda_pull_o` low), no write window is open, and every array byte reads 0xFF.
- R2: The address byte carries, from MSB to LSB, the fixed code 1010, two select bits, array address bit 8, and a read/write flag (1 = read). The slave pulls SDA low in the ninth clock only when the code is 1010 and the select bits equal `sel_i`. Otherwise it leaves SDA released.
- R3: A write consists of the address byte with the flag at 0, one byte for address bits 7..0, data bytes, then STOP. A single data byte lands at the nine-bit address formed by bit 8 from the address byte and bits 7..0 from the second byte.
- R4: Successive data bytes of one write advance only the low 4 address bits, wrapping inside the aligned 16-byte page. A 17th or later byte overwrites the earlier bytes from the start of the sequence.
- R5: A committed write opens a window of TWR_CYCLES system clocks after STOP. During that window the slave does not acknowledge its address. After the window closes it acknowledges again.
- R6: If `wp_i` is high at the STOP of a write, bytes at addresses 256..511 keep their old values and bytes below 256 are written. Every data byte is acknowledged either way.
- R7: A write whose STOP follows a partly shifted data byte (2 to 7 bits after the last acknowledge) is dropped as a whole. The array is unchanged and no write window opens.
- R8: A random read sets the address with a dummy write of the address byte and the low address byte. A repeated START and an address byte with the flag at 1 follow, and the first byte returned is the one at the set address.
- R9: A read that starts with only the address byte returns the byte that follows the last byte accessed.
- R10: During a read the address advances by one after every byte sent and wraps from 511 to 0. The read ends when the master does not acknowledge a byte.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 = pull SDA low; 0 = release |
| sel_i | input | 2 | Select strap compared with address byte bits 3..2 |
| wp_i | input | 1 | 1 = protect addresses 256..511 from writes |

## Verification
A wrong bit counter or a wrong state first shows up as an acknowledge in the wrong clock, or a missing one, within the same byte. The master sees this at once as a refused address or a stuck low SDA. A wrong address pointer, wrong page wrap or wrong protect decision is hidden during the write. It only shows up on a later read, as a data byte that differs from the reference array, so every write is followed by a read over the bytes it could have touched. A wrong write-window length shows up as an address acknowledge that comes too early or never comes, and the polling loop measures it in clock cycles.

// File: rtl/tw_pkg.sv
package tw_pkg;

    // Protocol state of the slave.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } tw_state_e;

    // Fixed family code in the upper nibble of the address byte.
    localparam logic [3:0] TW_FAMILY = 4'b1010;

    // Array address: 8 bits from the word byte plus one from the address byte.
    localparam int TW_ADDR_W = 9;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);

    typedef struct packed {
        logic [1:0] scl_m;
        logic [1:0] sda_m;
        logic       scl_p;
        logic       sda_p;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.scl_m = {s_q.scl_m[0], scl_i};
        s_d.sda_m = {s_q.sda_m[0], sda_i};
        s_d.scl_p = s_q.scl_m[1];
        s_d.sda_p = s_q.sda_m[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_s    = s_q.scl_m[1];
    assign sda_s    = s_q.sda_m[1];
    assign ev_rise  = scl_s & ~s_q.scl_p;
    assign ev_fall  = ~scl_s & s_q.scl_p;
    assign ev_start = scl_s & s_q.scl_p & s_q.sda_p & ~sda_s;
    assign ev_stop  = scl_s & s_q.scl_p & ~s_q.sda_p & sda_s;

endmodule

// File: rtl/tw_wr_timer.sv
module tw_wr_timer #(
    parameter int TWR_CYCLES = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(TWR_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = CW'(TWR_CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TWR_CYCLES)); // R5

    AST_WINDOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(start)) |-> (cnt_q == $past(cnt_q) - CW'(1))); // R5

endmodule

// File: rtl/tw_array.sv
module tw_array #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom
    import tw_pkg::*;
#(
    parameter int PAGE_W     = 4,
    parameter int TWR_CYCLES = 300000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [1:0] sel_i,
    input  logic       wp_i
);

    localparam int AW     = TW_ADDR_W;
    localparam int PAGE_N = 1 << PAGE_W;

    typedef struct packed {
        tw_state_e                 st;
        logic [3:0]                bitcnt;
        logic [7:0]                sh;
        logic                      sda_low;
        logic [AW-1:0]             ptr;
        logic                      a8;
        logic                      rw;
        logic                      mack;
        logic                      prot;
        logic [PAGE_N-1:0]         pmask;
        logic [PAGE_N-1:0][7:0]    pbuf;
        logic [PAGE_W:0]           cidx;
    } ctl_t;

    ctl_t r_d, r_q;

    logic scl_s, sda_s, ev_rise, ev_fall, ev_start, ev_stop;
    logic busy, tmr_start;
    logic mem_we;
    logic [AW-1:0] mem_wa;
    logic [7:0] mem_wd, mem_rd;

    tw_line_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    tw_wr_timer #(.TWR_CYCLES(TWR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (busy)
    );

    tw_array #(.AW(AW), .DW(8)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_wa),
        .wdata (mem_wd),
        .raddr (r_q.ptr),
        .rdata (mem_rd)
    );

    always_comb begin
        r_d       = r_q;
        tmr_start = 1'b0;
        mem_we    = 1'b0;
        mem_wa    = {r_q.ptr[AW-1:PAGE_W], r_q.cidx[PAGE_W-1:0]};
        mem_wd    = r_q.pbuf[r_q.cidx[PAGE_W-1:0]];

        // Commit engine: one buffered slot per cycle inside the write window.
        if (busy && !r_q.cidx[PAGE_W]) begin
            if (r_q.pmask[r_q.cidx[PAGE_W-1:0]] && !(r_q.prot && r_q.ptr[AW-1]))
                mem_we = 1'b1;
            r_d.cidx = r_q.cidx + (PAGE_W+1)'(1);
        end

        if (ev_start) begin
            r_d.st      = ST_DEV;
            r_d.bitcnt  = '0;
            r_d.sda_low = 1'b0;
        end else if (ev_stop) begin
            if (r_q.st == ST_WDATA && r_q.bitcnt <= 4'd1 && (|r_q.pmask) && !busy) begin
                tmr_start = 1'b1;
                r_d.cidx  = '0;
                r_d.prot  = wp_i;
            end
            r_d.st      = ST_IDLE;
            r_d.sda_low = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (ev_rise) begin
                        r_d.sh     = {r_q.sh[6:0], sda_s};
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end else if (ev_fall && r_q.bitcnt == 4'd8) begin
                        r_d.bitcnt = '0;
                        if (r_q.st == ST_DEV) begin
                            if (r_q.sh[7:4] == TW_FAMILY && r_q.sh[3:2] == sel_i && !busy) begin
                                r_d.st      = ST_DEV_ACK;
                                r_d.sda_low = 1'b1;
                                r_d.a8      = r_q.sh[1];
                                r_d.rw      = r_q.sh[0];
                            end else begin
                                r_d.st = ST_IDLE;
                            end
                        end else if (r_q.st == ST_WADDR) begin
                            r_d.ptr     = {r_q.a8, r_q.sh};
                            r_d.pmask   = '0;
                            r_d.st      = ST_WADDR_ACK;
                            r_d.sda_low = 1'b1;
                        end else begin
                            r_d.pbuf[r_q.ptr[PAGE_W-1:0]]  = r_q.sh;
                            r_d.pmask[r_q.ptr[PAGE_W-1:0]] = 1'b1;
                            r_d.ptr[PAGE_W-1:0] = r_q.ptr[PAGE_W-1:0] + PAGE_W'(1);
                            r_d.st      = ST_WDATA_ACK;
                            r_d.sda_low = 1'b1;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (ev_fall) begin
                        r_d.bitcnt = '0;
                        if (r_q.rw) begin
                            r_d.sh      = mem_rd;
                            r_d.sda_low = ~mem_rd[7];
                            r_d.st      = ST_RDATA;
                        end else begin
                            r_d.sda_low = 1'b0;
                            r_d.st      = ST_WADDR;
                        end
                    end
                end
                ST_WADDR_ACK, ST_WDATA_ACK: begin
                    if (ev_fall) begin
                        r_d.sda_low = 1'b0;
                        r_d.bitcnt  = '0;
                        r_d.st      = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (ev_rise) begin
                        r_d.bitcnt = r_q.bitcnt + 4'd1;
                    end else if (ev_fall) begin
                        if (r_q.bitcnt == 4'd8) begin
                            r_d.sda_low = 1'b0;
                            r_d.st      = ST_RACK;
                            r_d.ptr     = r_q.ptr + AW'(1);
                        end else begin
                            r_d.sh      = {r_q.sh[6:0], 1'b0};
                            r_d.sda_low = ~r_q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (ev_rise) begin
                        r_d.mack = ~sda_s;
                    end else if (ev_fall) begin
                        r_d.bitcnt = '0;
                        if (r_q.mack) begin
                            r_d.sh      = mem_rd;
                            r_d.sda_low = ~mem_rd[7];
                            r_d.st      = ST_RDATA;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cidx <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull_o = r_q.sda_low;

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DEV_ACK && r_q.sda_low) |-> !busy); // R5

    AST_COMMIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R5

    AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && !$past(ev_start) && !$past(ev_stop)) |-> $stable(r_q.sda_low)); // R11

    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RACK && $past(r_q.st) == ST_RDATA) |-> (r_q.ptr == $past(r_q.ptr) + AW'(1))); // R10

endmodule

// File: tb/tw_eeprom_test.sv
module tw_eeprom_test;

    localparam int Q   = 32;
    localparam int TWR = 3000;
    localparam logic [1:0] SEL = 2'b01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_pull;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int viol = 0;
    bit done = 1'b0;
    logic prev_scl = 1'b1;
    logic prev_pull = 1'b0;
    logic [7:0] refm [512];

    assign sda_line = m_sda & ~sda_pull;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tw_eeprom #(.PAGE_W(4), .TWR_CYCLES(TWR)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .sel_i      (SEL),
        .wp_i       (wp)
    );

    // R11 monitor: drive must not change across two high SCL samples.
    always @(negedge clk) begin
        if (rst_n && m_scl && prev_scl && sda_pull !== prev_pull) viol++;
        prev_scl  = m_scl;
        prev_pull = sda_pull;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(1);
        m_scl = 1'b1; wq(1);
        m_sda = 1'b0; wq(1);
        m_scl = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(1);
        m_scl = 1'b1; wq(1);
        m_sda = 1'b1; wq(2);
    endtask

    task automatic send_bit(logic b);
        m_sda = b;    wq(1);
        m_scl = 1'b1; wq(2);
        m_scl = 1'b0; wq(1);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wq(1);
        m_scl = 1'b1; wq(1);
        b = sda_line; wq(1);
        m_scl = 1'b0; wq(1);
    endtask

    task automatic send_byte(logic [7:0] v, output logic nak);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(nak);
    endtask

    task automatic recv_byte(logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    function automatic logic [7:0] dat(logic [7:0] seed, int i);
        return 8'(int'(seed) + i * 37);
    endfunction

    task automatic write_seq(logic [8:0] a, int n, logic [7:0] seed);
        logic nak;
        bus_start();
        send_byte({4'b1010, SEL, a[8], 1'b0}, nak);
        chk("R2 write address ack", nak, 0);
        send_byte(a[7:0], nak);
        chk("R3 word address ack", nak, 0);
        for (int i = 0; i < n; i++) begin
            send_byte(dat(seed, i), nak);
            chk("R6 data byte ack", nak, 0);
        end
        bus_stop();
        for (int i = 0; i < n; i++) begin
            logic [8:0] t;
            t = {a[8:4], 4'(a[3:0] + 4'(i))};
            if (!(wp && t[8])) refm[t] = dat(seed, i);
        end
    endtask

    task automatic wait_ready(output int polls, output logic nak);
        polls = 0;
        do begin
            bus_start();
            send_byte({4'b1010, SEL, 1'b0, 1'b0}, nak);
            bus_stop();
            polls++;
        end while (nak && polls < 20);
    endtask

    task automatic read_seq(logic [8:0] a, int n, string tag);
        logic nak;
        logic [7:0] v;
        bus_start();
        send_byte({4'b1010, SEL, a[8], 1'b0}, nak);
        chk("R8 dummy write ack", nak, 0);
        send_byte(a[7:0], nak);
        chk("R8 dummy word ack", nak, 0);
        bus_start();
        send_byte({4'b1010, SEL, 1'b0, 1'b1}, nak);
        chk("R8 read address ack", nak, 0);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            chk(tag, v, refm[9'(int'(a) + i)]);
        end
        bus_stop();
    endtask

    initial begin
        logic nak;
        logic [7:0] v;
        int polls;
        int t0;
        for (int i = 0; i < 512; i++) refm[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 SDA released after reset", sda_pull, 0);

        // R2: sweep every select value; only the strap value is acknowledged.
        for (int s = 0; s < 4; s++) begin
            bus_start();
            send_byte({4'b1010, 2'(s), 1'b0, 1'b0}, nak);
            bus_stop();
            chk("R2 select match", int'(!nak), int'(2'(s) == SEL));
        end
        bus_start();
        send_byte({4'b0110, SEL, 1'b0, 1'b0}, nak);
        bus_stop();
        chk("R2 wrong family code", nak, 1);

        // R3 and R5: byte write, busy refusal, then acknowledge polling.
        write_seq(9'h005, 1, 8'h5A);
        t0 = cyc;
        bus_start();
        send_byte({4'b1010, SEL, 1'b0, 1'b0}, nak);
        bus_stop();
        chk("R5 address refused in window", nak, 1);
        wait_ready(polls, nak);
        chk("R5 acknowledge resumes", nak, 0);
        chk("R5 window not shorter", int'((cyc - t0) >= TWR), 1);
        chk("R5 window not much longer", int'((cyc - t0) < TWR + 3000), 1);
        read_seq(9'h005, 1, "R3 byte write");

        // R4: 18 bytes into a page starting at low nibble C, upper half.
        write_seq(9'h12C, 18, 8'h30);
        wait_ready(polls, nak);
        read_seq(9'h120, 16, "R4 page wrap");
        read_seq(9'h130, 1, "R4 next page untouched");

        // R6: protect pin high for one upper and one lower write.
        wp = 1'b1;
        write_seq(9'h1F0, 4, 8'h81);
        wait_ready(polls, nak);
        write_seq(9'h010, 2, 8'hA0);
        wait_ready(polls, nak);
        wp = 1'b0;
        read_seq(9'h1F0, 4, "R6 protected half unchanged");
        read_seq(9'h010, 2, "R6 lower half written");

        // R7: STOP after a partial data byte.
        bus_start();
        send_byte({4'b1010, SEL, 1'b0, 1'b0}, nak);
        send_byte(8'h20, nak);
        send_byte(8'h11, nak);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        bus_start();
        send_byte({4'b1010, SEL, 1'b0, 1'b0}, nak);
        bus_stop();
        chk("R7 no window after partial byte", nak, 0);
        read_seq(9'h020, 1, "R7 partial write discarded");

        // R10: sequential read across 511 -> 0, ending on NACK.
        read_seq(9'h1FD, 8, "R10 sequential wrap");

        // R9: current-address read continues after the last byte (0x004).
        bus_start();
        send_byte({4'b1010, SEL, 1'b0, 1'b1}, nak);
        chk("R9 current read ack", nak, 0);
        recv_byte(1'b0, v);
        bus_stop();
        chk("R9 current address read", v, refm[9'h005]);

        chk("R11 SDA drive changes only with SCL low", viol, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule